// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Buffered Handshake

This block is a full-duplex asynchronous serial port for a small peripheral subsystem. An external baud-rate timer supplies a one-cycle clock enable (`baud_tick`). The block divides that enable by 8 or by 16 to form the transfer clock, and one transfer clock is one bit period on the line. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high.

On the transmit side there is one holding register with a busy flag. A write into it is the only thing that starts a frame. The start bit appears two and a half transfer clocks after the write. A write while the flag is set is rejected and reported as an error. The receive input first passes through a two-stage synchronizer. A falling edge becomes a start bit only if the line stays low for half a transfer clock. Each bit is then sampled near its middle. The finished byte lands in a receive register with a full flag, a framing-error flag and an overrun flag. Each direction raises a one-cycle completion pulse per frame.

Top module: `uart_duplex`

## Requirements
- R1: `div_sel` = 0 makes one bit period 8 baud ticks and `div_sel` = 1 makes it 16 baud ticks, for both transmit and receive.
- R2: A `tx_wr` pulse while `tx_busy` is 0 captures `tx_data` and sets `tx_busy` on the next cycle. `tx_busy` stays 1 until the frame ends.
- R3: The line falls for the start bit 2.5 bit periods (5 × period/2 baud ticks) after the clock edge that captured the write. Data bit 0 follows one bit period later.
- R4: `txd` idles at 1. A frame is a start bit of 0, then `tx_data[0]` through `tx_data[7]` in that order, then a stop bit of 1, each held for one bit period.
- R5: A `tx_wr` pulse while `tx_busy` is 1 raises `tx_wr_err` for one cycle on the next edge. It does not change the frame in progress and does not start another one.
- R6: `tx_done_irq` is high for exactly one cycle, on the edge that ends the stop bit. `tx_busy` falls on that same edge.
- R7: A low level on `rxd` counts as a start bit only if it lasts at least period/2 baud ticks. A shorter low pulse leaves the receiver idle, with no completion pulse and no change to `rx_full`.
- R8: The receiver samples each bit about half a bit period after its boundary and assembles the bits LSB first. At the stop-bit sample it writes the byte to `rx_data`, sets `rx_full` and pulses `rx_done_irq` for one cycle.
- R9: If the stop bit is sampled as 0, `rx_ferr` is set and the byte is still stored. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: `rx_rd` clears `rx_full`. A byte that completes while `rx_full` is 1 (and is not being read in that cycle) sets `rx_ovr`, and a byte that completes with the register empty clears it. `rx_ferr` and `rx_ovr` change only when a byte is stored.
- R11: After reset `txd` is 1 and `tx_busy`, `tx_wr_err`, `tx_done_irq`, `rx_full`, `rx_ferr`, `rx_ovr` and `rx_done_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable from the baud-rate timer |
| div_sel | input | 1 | Bit period select: 0 = 8 ticks, 1 = 16 ticks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive register |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Transmit register occupied; writes are illegal while set |
| tx_wr_err | output | 1 | One-cycle pulse: a write was rejected |
| tx_done_irq | output | 1 | One-cycle pulse at the end of each sent frame |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive register holds an unread byte |
| rx_ferr | output | 1 | Stop bit of the last stored byte was sampled low |
| rx_ovr | output | 1 | Last stored byte overwrote an unread one |
| rx_done_irq | output | 1 | One-cycle pulse at the end of each received frame |

## Verification
The bench uses the default divisors of 8 and 16 and holds `baud_tick` high. Each tick is then one clock, so a whole frame at either divisor takes a few hundred cycles. At that scale the bench can count the 2.5-period lead-in and the sample points cycle by cycle. The half-period start qualification becomes a 4-cycle window, so the bench can probe its exact boundary with 3-cycle and 4-cycle low pulses. In loopback the receiver reads back every transmitted byte, and in direct drive the bench injects framing errors and overruns.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {
    TXS_IDLE,
    TXS_LEAD,
    TXS_SHIFT
  } tx_state_t;

  typedef enum logic [2:0] {
    RXS_IDLE,
    RXS_QUAL,
    RXS_DATA,
    RXS_STOP,
    RXS_HOLD
  } rx_state_t;
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_LO      = 8,
  parameter int DIV_HI      = 16,
  parameter int LEAD_HALVES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              div_hi,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              busy,
  output logic              wr_err,
  output logic              done
);
  localparam int CW    = $clog2(DIV_HI) + 1;
  localparam int FRAME = DATA_W + 2;
  localparam int IW    = $clog2(FRAME + 1);
  localparam int HW    = $clog2(LEAD_HALVES + 1);

  tx_state_t        state;
  logic [CW-1:0]    period, half, tcnt;
  logic [HW-1:0]    hcnt;
  logic [IW-1:0]    bidx;
  logic [FRAME-1:0] sh;

  assign period = div_hi ? CW'(DIV_HI) : CW'(DIV_LO);
  assign half   = period >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TXS_IDLE;
      txd    <= 1'b1;
      busy   <= 1'b0;
      wr_err <= 1'b0;
      done   <= 1'b0;
      tcnt   <= '0;
      hcnt   <= '0;
      bidx   <= '0;
      sh     <= '1;
    end else begin
      wr_err <= wr & busy;
      done   <= 1'b0;
      case (state)
        TXS_IDLE: begin
          if (wr) begin
            sh    <= {1'b1, wr_data, 1'b0};
            busy  <= 1'b1;
            tcnt  <= '0;
            hcnt  <= '0;
            state <= TXS_LEAD;
          end
        end
        TXS_LEAD: begin
          if (tick) begin
            if (tcnt == half - 1'b1) begin
              tcnt <= '0;
              if (hcnt == HW'(LEAD_HALVES - 1)) begin
                state <= TXS_SHIFT;
                txd   <= sh[0];
                sh    <= {1'b1, sh[FRAME-1:1]};
                bidx  <= '0;
              end else begin
                hcnt <= hcnt + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        TXS_SHIFT: begin
          if (tick) begin
            if (tcnt == period - 1'b1) begin
              tcnt <= '0;
              if (bidx == IW'(FRAME - 1)) begin
                state <= TXS_IDLE;
                busy  <= 1'b0;
                done  <= 1'b1;
                txd   <= 1'b1;
              end else begin
                bidx <= bidx + 1'b1;
                txd  <= sh[0];
                sh   <= {1'b1, sh[FRAME-1:1]};
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: state <= TXS_IDLE;
      endcase
    end
  end

  assert_err_on_busy_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && busy) |=> wr_err);
  assert_done_frees_buffer_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_done_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_lead_keeps_line_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_LO = 8,
  parameter int DIV_HI = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              div_hi,
  input  logic              rxs,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              ferr,
  output logic              ovr,
  output logic              done
);
  localparam int CW = $clog2(DIV_HI) + 1;
  localparam int IW = $clog2(DATA_W + 1);

  rx_state_t         state;
  logic [CW-1:0]     period, half, tcnt;
  logic [IW-1:0]     bidx;
  logic [DATA_W-1:0] sh;
  logic              store;

  assign period = div_hi ? CW'(DIV_HI) : CW'(DIV_LO);
  assign half   = period >> 1;
  assign store  = (state == RXS_STOP) && tick && (tcnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RXS_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      sh    <= '0;
    end else begin
      case (state)
        RXS_IDLE: begin
          if (tick && !rxs) begin
            state <= RXS_QUAL;
            tcnt  <= CW'(1);
          end
        end
        RXS_QUAL: begin
          if (tick) begin
            if (rxs) begin
              state <= RXS_IDLE;
            end else if (tcnt == half - 1'b1) begin
              state <= RXS_DATA;
              tcnt  <= '0;
              bidx  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RXS_DATA: begin
          if (tick) begin
            if (tcnt == period - 1'b1) begin
              tcnt <= '0;
              sh   <= {rxs, sh[DATA_W-1:1]};
              if (bidx == IW'(DATA_W - 1)) state <= RXS_STOP;
              else                        bidx  <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RXS_STOP: begin
          if (tick) begin
            if (store) begin
              tcnt  <= '0;
              state <= rxs ? RXS_IDLE : RXS_HOLD;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RXS_HOLD: begin
          if (rxs) state <= RXS_IDLE;
        end
        default: state <= RXS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      ferr <= 1'b0;
      ovr  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= store;
      if (store) begin
        data <= sh;
        ferr <= ~rxs;
        ovr  <= full & ~rd;
        full <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
    end
  end

  assert_done_sets_full_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> full);
  assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_full_rises_on_store_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> done);
  assert_ferr_only_on_store_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ferr));
  assert_ovr_only_on_store_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ovr));
endmodule

// File: rtl/uart_duplex.sv
module uart_duplex #(
  parameter int DATA_W      = 8,
  parameter int DIV_LO      = 8,
  parameter int DIV_HI      = 16,
  parameter int LEAD_HALVES = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              div_sel,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              rxd,
  output logic              txd,
  output logic              tx_busy,
  output logic              tx_wr_err,
  output logic              tx_done_irq,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ferr,
  output logic              rx_ovr,
  output logic              rx_done_irq
);
  logic rxd_s;

  uart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  uart_tx #(
    .DATA_W(DATA_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .LEAD_HALVES(LEAD_HALVES)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .tick   (baud_tick),
    .div_hi (div_sel),
    .wr     (tx_wr),
    .wr_data(tx_data),
    .txd    (txd),
    .busy   (tx_busy),
    .wr_err (tx_wr_err),
    .done   (tx_done_irq)
  );

  uart_rx #(
    .DATA_W(DATA_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)
  ) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .div_hi(div_sel),
    .rxs   (rxd_s),
    .rd    (rx_rd),
    .data  (rx_data),
    .full  (rx_full),
    .ferr  (rx_ferr),
    .ovr   (rx_ovr),
    .done  (rx_done_irq)
  );
endmodule

// File: tb/uart_duplex_test.sv
`timescale 1ns/1ps
module uart_duplex_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b1;
  logic       div_sel = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_rd = 1'b0;
  logic       lb = 1'b1;
  logic       rxd_drv = 1'b1;
  logic       rxd;
  logic       txd, tx_busy, tx_wr_err, tx_done_irq;
  logic [7:0] rx_data;
  logic       rx_full, rx_ferr, rx_ovr, rx_done_irq;

  int nchk = 0;
  int nfail = 0;
  int ntx = 0;
  int nrx = 0;

  assign rxd = lb ? txd : rxd_drv;

  uart_duplex uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .div_sel(div_sel),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rxd(rxd),
    .txd(txd), .tx_busy(tx_busy), .tx_wr_err(tx_wr_err), .tx_done_irq(tx_done_irq),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
    .rx_done_irq(rx_done_irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst) begin
      if (tx_done_irq) ntx++;
      if (rx_done_irq) nrx++;
    end
  end

  // each entry: {div_sel, byte}
  localparam logic [8:0] VEC [4] = '{9'h0A5, 9'h13C, 9'h001, 9'h1FE};

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk("R10 read clears full", rx_full, 0);
  endtask

  task automatic tx_frame(input logic d16, input logic [7:0] d);
    int n, per, hf, ntx0, nrx0;
    per = d16 ? 16 : 8;
    hf = per / 2;
    lb = 1'b1;
    div_sel = d16;
    repeat (3) @(negedge clk);
    ntx0 = ntx;
    nrx0 = nrx;
    tx_wr = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R2 busy after write", tx_busy, 1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (txd && n < 400);
    chk("R3 R1 start delay", n, 5 * hf);
    repeat (hf) @(negedge clk);
    chk("R4 start bit", txd, 0);
    for (int k = 0; k < 8; k++) begin
      repeat (per) @(negedge clk);
      chk("R4 R1 data bit", txd, d[k]);
    end
    repeat (per) @(negedge clk);
    chk("R4 stop bit", txd, 1);
    chk("R2 busy during stop", tx_busy, 1);
    repeat (hf) @(negedge clk);
    chk("R6 done pulse", tx_done_irq, 1);
    chk("R6 busy cleared", tx_busy, 0);
    @(negedge clk);
    chk("R6 done one cycle", tx_done_irq, 0);
    chk("R6 one tx irq", ntx - ntx0, 1);
    chk("R8 loopback data", rx_data, d);
    chk("R8 full set", rx_full, 1);
    chk("R8 one rx irq", nrx - nrx0, 1);
    chk("R9 no framing error", rx_ferr, 0);
    read_rx();
  endtask

  task automatic rx_send(input logic d16, input logic [7:0] d, input logic stopb);
    int per;
    logic [9:0] fr;
    per = d16 ? 16 : 8;
    lb = 1'b0;
    div_sel = d16;
    fr = {stopb, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rxd_drv = fr[k];
      repeat (per) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (2 * per) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 txd idle", txd, 1);
    chk("R11 busy", tx_busy, 0);
    chk("R11 wr_err", tx_wr_err, 0);
    chk("R11 tx irq", tx_done_irq, 0);
    chk("R11 full", rx_full, 0);
    chk("R11 ferr", rx_ferr, 0);
    chk("R11 ovr", rx_ovr, 0);
    chk("R11 rx irq", rx_done_irq, 0);

    for (int i = 0; i < 4; i++) tx_frame(VEC[i][8], VEC[i][7:0]);

    // R5: write while busy is rejected
    lb = 1'b1;
    div_sel = 1'b0;
    n0 = ntx;
    tx_wr = 1'b1;
    tx_data = 8'h5A;
    @(negedge clk);
    tx_data = 8'hC3;
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R5 error pulse", tx_wr_err, 1);
    @(negedge clk);
    chk("R5 error one cycle", tx_wr_err, 0);
    repeat (200) @(negedge clk);
    chk("R5 single frame", ntx - n0, 1);
    chk("R5 first byte kept", rx_data, 8'h5A);
    chk("R5 line idle after", txd, 1);
    chk("R5 buffer free", tx_busy, 0);
    read_rx();

    // R7: short low pulse is a glitch
    lb = 1'b0;
    n0 = nrx;
    rxd_drv = 1'b0;
    repeat (3) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (150) @(negedge clk);
    chk("R7 glitch no irq", nrx - n0, 0);
    chk("R7 glitch no full", rx_full, 0);
    // R7: low for exactly half a period is a start bit, reads as all ones
    rxd_drv = 1'b0;
    repeat (4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (150) @(negedge clk);
    chk("R7 min start accepted", nrx - n0, 1);
    chk("R7 data all ones", rx_data, 8'hFF);
    read_rx();

    // R9 framing error, byte still stored
    rx_send(1'b0, 8'h96, 1'b0);
    chk("R9 ferr set", rx_ferr, 1);
    chk("R9 data stored", rx_data, 8'h96);
    chk("R9 full", rx_full, 1);
    // R10 overrun
    rx_send(1'b0, 8'h21, 1'b1);
    chk("R10 ovr set", rx_ovr, 1);
    chk("R10 new data", rx_data, 8'h21);
    chk("R9 ferr cleared by good frame", rx_ferr, 0);
    read_rx();
    chk("R10 ovr holds after read", rx_ovr, 1);
    // R1 divide-by-16 reception, R10 overrun clears
    rx_send(1'b1, 8'h7E, 1'b1);
    chk("R1 R8 div16 data", rx_data, 8'h7E);
    chk("R10 ovr cleared", rx_ovr, 0);
    read_rx();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule